// File: doc/BRIEF.md
# Reconfigurable Walsh-Code Spread-Spectrum Bus

This block models a shared bus on which eight units transmit and receive at the same time, separated by orthogonal Walsh spreading codes rather than by time slots. Every unit has two transmit slots and two receive slots. An enabled transmit slot turns its data bit into +1 or -1 and multiplies it by the chips of its assigned code. The bus adds the contributions of all enabled slots into one signed multilevel value per clock. An enabled receive slot multiplies that value by its own code, accumulates over the 8-chip period and decides the bit from the sign of the sum.

A write port maps codes to the transmit and receive slots while the bus runs. Writes land in a pending table. The pending table is copied to the active table only at a period boundary, so no symbol is spread or despread with two different maps. A unit that enables both transmit slots on two codes sends two bits per period. Receive slots on several units that hold the same code all recover the same stream, which gives multicast.

Slot k is flattened as k = unit*2 + slot in `tx_data_i`, `rx_bit_o` and `rx_valid_o`.

Top module: `cdma_walsh_bus`

## Requirements
- R1: `chip_idx_o` is 0 during reset and the first cycle after it, then advances by one per clock and wraps from 7 to 0. In chip j, code c has chip value -1 when popcount(c & j) is odd and +1 otherwise. A transmit slot with bit 1 contributes +chip and one with bit 0 contributes -chip.
- R2: `bus_o` is the 6-bit two's-complement sum of the contributions of every enabled transmit slot in that cycle. A disabled slot contributes 0.
- R3: `tx_data_i` is sampled at the rising edge that ends chip 7 and is spread over the next 8 chips. The receive outputs update at the edge that ends the last of those chips and hold at all other edges. `rx_done_o` is high for exactly the one cycle that follows each update, and that cycle is chip 0.
- R4: A receive slot's correlation is the sum over one period of bus value times its code chip. `rx_bit_o` is 1 exactly when the correlation is positive. `rx_valid_o` is 0 when the correlation is zero or the slot is disabled, and a disabled slot also reports bit 0.
- R5: When each received code is driven by exactly one transmit slot, every enabled receive slot recovers that slot's bit with valid 1, whatever the other codes carry.
- R6: A unit with both transmit slots enabled on two distinct codes delivers two independent bits per period, one on each code.
- R7: Receive slots on several units that hold the same code all report the same bit in the same period.
- R8: A configuration write (`cfg_rx_i` 0 selects the transmit table, 1 selects the receive table; fields are enable and 3-bit code) affects the bus and the receivers only from the next chip 0. Any chips that remain in the current period still use the previous map.
- R9: Reset clears `rx_bit_o`, `rx_valid_o` and `rx_done_o` and loads a default map. Transmit slot 0 of unit u uses code u. Receive slot 0 of unit u uses code u XOR 1, which makes pairs 0-1, 2-3, 4-5 and 6-7. All slot-1 entries are disabled, and the sampled data is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one chip per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 16 | Data bit per transmit slot, index unit*2+slot |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rx_i | input | 1 | Table select: 0 transmit, 1 receive |
| cfg_unit_i | input | 3 | Unit addressed by the write |
| cfg_slot_i | input | 1 | Slot addressed by the write |
| cfg_en_i | input | 1 | Enable value written to the slot |
| cfg_code_i | input | 3 | Walsh code index written to the slot |
| chip_idx_o | output | 3 | Current chip index within the period |
| bus_o | output | 6 | Signed multilevel bus value for the current chip |
| rx_bit_o | output | 16 | Decided bit per receive slot |
| rx_valid_o | output | 16 | Nonzero-correlation flag per receive slot |
| rx_done_o | output | 1 | One-cycle strobe after receive outputs update |

## Verification
Two things can happen in the same period: a map change written partway through a period, and symbols being spread and despread under the map already in force. The bench writes a new transmit entry at chip 2. It then compares `bus_o` chip by chip against the old map until chip 7 and against the new map from the next chip 0. It also checks that the receive results for the disturbed period reflect only the old map. A second overlap is at the boundary edge itself, where new data is sampled, the map commits and the previous period's decisions come out together. Every period of every scenario is therefore judged at chip 0 against a correlation model fed with the data and map of the period before.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  // Walsh chip sign: 1 means -1, 0 means +1
  function automatic logic chip_neg(input logic [7:0] code, input logic [7:0] chip);
    return ^(code & chip);
  endfunction
endpackage

// File: rtl/cdma_cfg_table.sv
module cdma_cfg_table #(
  parameter int N_UNITS = 8,
  parameter int N_SLOTS = 2,
  parameter int CW      = 3,
  parameter int UW      = 3,
  parameter int SW      = 1,
  localparam int NS     = N_UNITS * N_SLOTS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             cfg_we_i,
  input  logic             cfg_rx_i,
  input  logic [UW-1:0]    cfg_unit_i,
  input  logic [SW-1:0]    cfg_slot_i,
  input  logic             cfg_en_i,
  input  logic [CW-1:0]    cfg_code_i,
  output logic [NS-1:0]    tx_en_o,
  output logic [NS*CW-1:0] tx_code_o,
  output logic [NS-1:0]    rx_en_o,
  output logic [NS*CW-1:0] rx_code_o
);
  for (genvar k = 0; k < NS; k++) begin : g_ent
    localparam int U = k / N_SLOTS;
    localparam int S = k % N_SLOTS;
    localparam logic DEF_EN = (S == 0);
    localparam logic [CW-1:0] DEF_TX = CW'(U);
    localparam logic [CW-1:0] DEF_RX = CW'(U ^ 1);

    logic          sel;
    logic          tp_en_q, ta_en_q, rp_en_q, ra_en_q;
    logic [CW-1:0] tp_code_q, ta_code_q, rp_code_q, ra_code_q;

    assign sel = cfg_we_i && (cfg_unit_i == UW'(U)) && (cfg_slot_i == SW'(S));

    // pending entries take writes at once; active entries copy them at the boundary
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tp_en_q <= DEF_EN; tp_code_q <= DEF_TX;
        ta_en_q <= DEF_EN; ta_code_q <= DEF_TX;
        rp_en_q <= DEF_EN; rp_code_q <= DEF_RX;
        ra_en_q <= DEF_EN; ra_code_q <= DEF_RX;
      end else begin
        if (sel && !cfg_rx_i) begin
          tp_en_q   <= cfg_en_i;
          tp_code_q <= cfg_code_i;
        end
        if (sel && cfg_rx_i) begin
          rp_en_q   <= cfg_en_i;
          rp_code_q <= cfg_code_i;
        end
        if (commit_i) begin
          ta_en_q   <= tp_en_q;
          ta_code_q <= tp_code_q;
          ra_en_q   <= rp_en_q;
          ra_code_q <= rp_code_q;
        end
      end
    end

    assign tx_en_o[k]             = ta_en_q;
    assign tx_code_o[k*CW +: CW]  = ta_code_q;
    assign rx_en_o[k]             = ra_en_q;
    assign rx_code_o[k*CW +: CW]  = ra_code_q;
  end
endmodule

// File: rtl/cdma_spread.sv
module cdma_spread import cdma_pkg::*; #(
  parameter int NS    = 16,
  parameter int CW    = 3,
  parameter int BUS_W = 6
) (
  input  logic [CW-1:0]           chip_i,
  input  logic [NS-1:0]           sym_i,
  input  logic [NS-1:0]           tx_en_i,
  input  logic [NS*CW-1:0]        tx_code_i,
  output logic signed [BUS_W-1:0] bus_o
);
  localparam logic signed [BUS_W-1:0] ONE = BUS_W'(1);

  logic signed [BUS_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int k = 0; k < NS; k++) begin
      if (tx_en_i[k]) begin
        // bit 1 with chip +1, or bit 0 with chip -1, gives +1
        if (sym_i[k] ^ chip_neg(8'(tx_code_i[k*CW +: CW]), 8'(chip_i))) sum = sum + ONE;
        else                                                           sum = sum - ONE;
      end
    end
  end

  assign bus_o = sum;
endmodule

// File: rtl/cdma_despread.sv
module cdma_despread import cdma_pkg::*; #(
  parameter int CW    = 3,
  parameter int BUS_W = 6,
  parameter int ACC_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    period_end_i,
  input  logic [CW-1:0]           chip_i,
  input  logic signed [BUS_W-1:0] bus_i,
  input  logic                    en_i,
  input  logic [CW-1:0]           code_i,
  output logic                    bit_o,
  output logic                    valid_o
);
  logic signed [ACC_W-1:0] bus_x, term, acc_q, acc_d;
  logic                    bit_q, valid_q;

  assign bus_x = ACC_W'(bus_i);

  always_comb begin
    term = '0;
    if (en_i) term = chip_neg(8'(code_i), 8'(chip_i)) ? -bus_x : bus_x;
    acc_d = acc_q + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else if (period_end_i) begin
      acc_q   <= '0;
      bit_q   <= en_i && (acc_d > 0);
      valid_q <= en_i && (acc_d != 0);
    end else begin
      acc_q   <= acc_d;
    end
  end

  assign bit_o   = bit_q;
  assign valid_o = valid_q;

  AST_BIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q |-> valid_q); // R4
  AST_HOLD_MID_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(period_end_i) |-> ($stable(bit_q) && $stable(valid_q))); // R3
endmodule

// File: rtl/cdma_walsh_bus.sv
module cdma_walsh_bus #(
  parameter int N_UNITS  = 8,
  parameter int N_SLOTS  = 2,
  parameter int CODE_LEN = 8,
  localparam int CW    = $clog2(CODE_LEN),
  localparam int UW    = $clog2(N_UNITS),
  localparam int SW    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int NS    = N_UNITS * N_SLOTS,
  localparam int BUS_W = $clog2(NS + 1) + 1,
  localparam int ACC_W = BUS_W + CW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NS-1:0]           tx_data_i,
  input  logic                    cfg_we_i,
  input  logic                    cfg_rx_i,
  input  logic [UW-1:0]           cfg_unit_i,
  input  logic [SW-1:0]           cfg_slot_i,
  input  logic                    cfg_en_i,
  input  logic [CW-1:0]           cfg_code_i,
  output logic [CW-1:0]           chip_idx_o,
  output logic signed [BUS_W-1:0] bus_o,
  output logic [NS-1:0]           rx_bit_o,
  output logic [NS-1:0]           rx_valid_o,
  output logic                    rx_done_o
);
  logic [CW-1:0]           chip_q;
  logic                    period_end;
  logic [NS-1:0]           sym_q;
  logic                    done_q;
  logic [NS-1:0]           tx_en, rx_en;
  logic [NS*CW-1:0]        tx_code, rx_code;
  logic signed [BUS_W-1:0] bus;

  assign period_end = (chip_q == CW'(CODE_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_q <= '0;
      sym_q  <= '0;
      done_q <= 1'b0;
    end else begin
      chip_q <= chip_q + 1'b1;
      done_q <= period_end;
      if (period_end) sym_q <= tx_data_i;
    end
  end

  cdma_cfg_table #(
    .N_UNITS(N_UNITS), .N_SLOTS(N_SLOTS), .CW(CW), .UW(UW), .SW(SW)
  ) u_cfg (
    .clk_i, .rst_ni,
    .commit_i  (period_end),
    .cfg_we_i, .cfg_rx_i, .cfg_unit_i, .cfg_slot_i, .cfg_en_i, .cfg_code_i,
    .tx_en_o   (tx_en),
    .tx_code_o (tx_code),
    .rx_en_o   (rx_en),
    .rx_code_o (rx_code)
  );

  cdma_spread #(.NS(NS), .CW(CW), .BUS_W(BUS_W)) u_spread (
    .chip_i    (chip_q),
    .sym_i     (sym_q),
    .tx_en_i   (tx_en),
    .tx_code_i (tx_code),
    .bus_o     (bus)
  );

  for (genvar k = 0; k < NS; k++) begin : g_rx
    cdma_despread #(.CW(CW), .BUS_W(BUS_W), .ACC_W(ACC_W)) u_despread (
      .clk_i, .rst_ni,
      .period_end_i (period_end),
      .chip_i       (chip_q),
      .bus_i        (bus),
      .en_i         (rx_en[k]),
      .code_i       (rx_code[k*CW +: CW]),
      .bit_o        (rx_bit_o[k]),
      .valid_o      (rx_valid_o[k])
    );
  end

  assign chip_idx_o = chip_q;
  assign bus_o      = bus;
  assign rx_done_o  = done_q;

  AST_CHIP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> (chip_q == '0)); // R1
  AST_CHIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end |=> (chip_q == CW'($past(chip_q) + 1'b1))); // R1
  AST_BUS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(bus) <= $countones(tx_en)) && ($signed(bus) >= -$countones(tx_en))); // R2
  AST_BUS_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus[0] == (^tx_en)); // R2
  AST_DONE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (chip_q == '0)); // R3
  AST_CFG_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({tx_en, tx_code, rx_en, rx_code}) |-> (chip_q == '0)); // R8
endmodule

// File: tb/cdma_walsh_bus_tb_top.sv
`timescale 1ns/1ps
module cdma_walsh_bus_tb_top;
  localparam int NS   = 16;
  localparam int NSYM = 6;
  localparam logic [63:0] DEF_TX = 64'h0F0E0D0C0B0A0908;
  localparam logic [63:0] DEF_RX = 64'h0E0F0C0D0A0B0809;

  // per slot k, nibble k = {enable, code[2:0]}; upper 64 bits transmit map, lower receive map
  localparam logic [127:0] SCEN [5] = '{
    {64'h08090A0B0C0D0E0F, 64'h09080B0A0D0C0F0E},  // disjoint pairs
    {64'h0E0C0F00DB0A0908, 64'hDBDB0A0ECF0C0809},  // two-code sender, multicast
    {64'h0000000000000A0D, 64'h0000800A0B0D0000},  // undriven code
    {64'h0000000000000A0A, 64'h0000000A00000000},  // code collision
    {64'h8F9EADBCCBDAE9F8, 64'h0F0E0D0C0B0A0908}   // all slots driving
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NS-1:0]     tx_data_i = '0;
  logic              cfg_we_i = 1'b0, cfg_rx_i = 1'b0, cfg_slot_i = 1'b0, cfg_en_i = 1'b0;
  logic [2:0]        cfg_unit_i = '0, cfg_code_i = '0;
  logic [2:0]        chip_idx_o;
  logic signed [5:0] bus_o;
  logic [NS-1:0]     rx_bit_o, rx_valid_o;
  logic              rx_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  cdma_walsh_bus dut_i (
    .clk_i, .rst_ni, .tx_data_i,
    .cfg_we_i, .cfg_rx_i, .cfg_unit_i, .cfg_slot_i, .cfg_en_i, .cfg_code_i,
    .chip_idx_o, .bus_o, .rx_bit_o, .rx_valid_o, .rx_done_o
  );

  function automatic int chip_val(input int c, input int j);
    return ($countones(c & j) % 2 == 1) ? -1 : 1;
  endfunction

  function automatic int bus_ref(input logic [63:0] txm, input logic [15:0] d, input int j);
    int s;
    s = 0;
    for (int k = 0; k < NS; k++)
      if (txm[4*k+3]) s += (d[k] ? 1 : -1) * chip_val(int'(txm[4*k +: 3]), j);
    return s;
  endfunction

  function automatic void rx_ref(input logic [63:0] txm, input logic [63:0] rxm,
                                 input logic [15:0] d, input int k,
                                 output logic b, output logic v);
    int corr;
    corr = 0;
    if (!rxm[4*k+3]) begin
      b = 1'b0; v = 1'b0;
      return;
    end
    for (int j = 0; j < 8; j++) corr += bus_ref(txm, d, j) * chip_val(int'(rxm[4*k +: 3]), j);
    b = corr > 0;
    v = corr != 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_rx(input logic [63:0] txm, input logic [63:0] rxm,
                          input logic [15:0] d, input string tag);
    logic b, v;
    chk({tag, " R3 done strobe"}, int'(rx_done_o), 1);
    for (int k = 0; k < NS; k++) begin
      rx_ref(txm, rxm, d, k, b, v);
      chk($sformatf("%s R4 bit slot %0d", tag, k), int'(rx_bit_o[k]), int'(b));
      chk($sformatf("%s R4 valid slot %0d", tag, k), int'(rx_valid_o[k]), int'(v));
    end
  endtask

  task automatic wait_chip(input int j);
    do @(negedge clk_i); while (int'(chip_idx_o) != j);
  endtask

  task automatic cfg_write(input logic rx, input int k, input logic en, input logic [2:0] code);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_rx_i = rx; cfg_unit_i = 3'(k / 2); cfg_slot_i = 1'(k % 2);
    cfg_en_i = en; cfg_code_i = code;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_scen(input logic [63:0] txm, input logic [63:0] rxm, input string tag);
    logic [15:0] d, p;
    for (int k = 0; k < NS; k++) begin
      cfg_write(1'b0, k, txm[4*k+3], txm[4*k +: 3]);
      cfg_write(1'b1, k, rxm[4*k+3], rxm[4*k +: 3]);
    end
    wait_chip(7);
    d = 16'($urandom);
    p = d;
    tx_data_i = d;
    for (int n = 0; n < NSYM; n++) begin
      for (int j = 0; j < 8; j++) begin
        @(negedge clk_i);
        chk({tag, " R1 chip index"}, int'(chip_idx_o), j);
        chk({tag, " R2 bus sum"}, int'($signed(bus_o)), bus_ref(txm, d, j));
        if (j == 0 && n > 0) check_rx(txm, rxm, p, tag);
        if (j == 7) begin
          p = d;
          d = 16'($urandom);
          tx_data_i = d;
        end
      end
    end
    @(negedge clk_i);
    check_rx(txm, rxm, p, tag);
  endtask

  initial begin
    logic [15:0] d;
    logic [63:0] tx_new;
    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk("R9 reset chip", int'(chip_idx_o), 0);
    chk("R9 reset done", int'(rx_done_o), 0);
    chk("R9 reset bits", int'(rx_bit_o), 0);
    chk("R9 reset valid", int'(rx_valid_o), 0);
    chk("R9 R2 reset bus", int'($signed(bus_o)), bus_ref(DEF_TX, 16'h0, 0));
    rst_ni = 1'b1;

    // R9 default map, then R8 write landing mid-period
    tx_new = DEF_TX | (64'hA << 4);
    wait_chip(7);
    d = 16'($urandom);
    tx_data_i = d;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk_i);
      if (j == 0) check_rx(DEF_TX, DEF_RX, 16'h0, "R9 first period");
      chk(j < 3 ? "R9 R2 default bus" : "R8 old map holds", int'($signed(bus_o)),
          bus_ref(DEF_TX, d, j));
      if (j == 2) begin
        cfg_we_i = 1'b1; cfg_rx_i = 1'b0; cfg_unit_i = 3'd0; cfg_slot_i = 1'b1;
        cfg_en_i = 1'b1; cfg_code_i = 3'd2;
      end
      if (j == 3) cfg_we_i = 1'b0;
    end
    for (int j = 0; j < 8; j++) begin
      @(negedge clk_i);
      if (j == 0) check_rx(DEF_TX, DEF_RX, d, "R9 R5 default pairs");
      chk("R8 new map at boundary", int'($signed(bus_o)), bus_ref(tx_new, d, j));
    end
    @(negedge clk_i);
    check_rx(tx_new, DEF_RX, d, "R8 new map decisions");

    // table of map scenarios
    for (int s = 0; s < 5; s++) begin
      string tag;
      case (s)
        0:       tag = "R5 pairs";
        1:       tag = "R6 R7 multi";
        2:       tag = "R4 undriven";
        3:       tag = "R4 collision";
        default: tag = "R2 full load";
      endcase
      run_scen(SCEN[s][127:64], SCEN[s][63:0], tag);
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule